// File: doc/BRIEF.md
# Camera control serial slave

This block is the configuration port of an image sensor. It sits on a two-wire, open-drain serial bus as a slave. The host always drives the bus clock and frames every message. The block never masters the bus. It only pulls the data line low or releases it. The two bus inputs are brought into the system clock domain through two flip-flops each. Start and stop conditions are recognised as data-line edges while the clock line is high.

The device address has seven bits. The upper five come from the parameter `ADDR_HI`, and the lower two are read live from the strap inputs `strap_addr_i`. The first byte of every message carries the address and a direction bit in bit 0 (0 = host writes, 1 = host reads). The second byte is always sent by the host and is the register index. In a write, each further byte is stored at the index, and the index then advances by one. In a read, the slave returns bytes starting at the index and advances the index after each byte. It keeps returning bytes until the host answers with a not-acknowledge. Messages carry three bytes (one data byte) or five bytes (three data bytes).

Register 0 is the control byte. Its bit positions are: bit 0 = linear output (0 = gamma-corrected), bit 1 = auto exposure, bit 2 = auto gain, bit 3 = backlit mode, bit 4 = 625-line video standard. Bits 7..5 read as zero. On reset, the five bits load from their strap pins. Serial writes can then override them. Registers 1 to `STAT_BYTES` are read-only status bytes taken from `stat_i`, with the most significant byte at index 1. Every other index reads 0 and ignores writes. The effective auto-gain output is 1 only when both the auto-gain bit and the auto-exposure bit are 1.

The controller has six states:
- `ST_IDLE` waits for a start.
- `ST_RX` shifts in a byte on rising bus-clock edges.
- `ST_ACK` pulls data low for the acknowledge slot.
- `ST_TX` shifts a byte out on falling edges.
- `ST_MACK` samples the host's acknowledge.
- `ST_SKIP` stays silent until the next start or stop.

A start moves any state to `ST_RX` and clears the bit and byte counts. A stop moves any state to `ST_IDLE`. The other transitions are:
- `ST_RX` → `ST_ACK` after any byte except a non-matching address byte.
- `ST_RX` → `ST_SKIP` after a non-matching address byte.
- `ST_ACK` → `ST_TX` for read data.
- `ST_ACK` → `ST_RX` otherwise.
- `ST_TX` → `ST_MACK` after eight bits.
- `ST_MACK` → `ST_TX` on an acknowledge.
- `ST_MACK` → `ST_SKIP` on a not-acknowledge.

Top module: `cam_ctl_slave`

## Requirements
- R1: During and after reset, the five control outputs equal the strap pins: `agc_o` = strap auto gain AND strap auto exposure. `sda_oe_o` is 0.
- R2: The slave acknowledges an address byte only when bits 7..1 equal {`ADDR_HI`, `strap_addr_i`}. On any other address it never pulls the data line low and changes no register until the next start or stop.
- R3: A three-byte write to index 0 stores data bits 4..0 into the control byte (bit 0 linear, 1 auto exposure, 2 auto gain, 3 backlit, 4 video standard). The matching outputs follow, and every byte of the message is acknowledged.
- R4: `agc_o` is 1 only when control bit 2 and control bit 1 are both 1.
- R5: A read at index 0 returns the control byte with bits 7..5 as zero.
- R6: A read at index k (1 ≤ k ≤ `STAT_BYTES`) returns byte k of `stat_i`, counted from the most significant byte. Indices above `STAT_BYTES` read 0. Consecutive read bytes come from consecutive indices.
- R7: In a five-byte write, data bytes go to the index, index+1 and index+2. Writes that land on status or unused indices have no effect.
- R8: After the host not-acknowledges a read byte, the slave releases the data line and keeps it released until the next start.
- R9: A start, including a repeated start in the middle of a message, restarts framing with an address byte. A stop returns the slave to idle.
- R10: The slave changes its data-line drive only while the synchronised bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock from host |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 = pull the data line low |
| strap_addr_i | input | 2 | Low two address bits |
| strap_linear_i | input | 1 | Reset value of linear-output bit |
| strap_aec_i | input | 1 | Reset value of auto-exposure bit |
| strap_agc_i | input | 1 | Reset value of auto-gain bit |
| strap_backlit_i | input | 1 | Reset value of backlit bit |
| strap_std_i | input | 1 | Reset value of video-standard bit |
| stat_i | input | STAT_BYTES*8 | Status bytes, MSB byte at index 1 |
| linear_o | output | 1 | Effective linear-output select |
| aec_o | output | 1 | Effective auto-exposure enable |
| agc_o | output | 1 | Effective auto-gain enable |
| backlit_o | output | 1 | Effective backlit mode |
| std_o | output | 1 | Effective video standard |

## Verification
The assertions take for granted that the host changes the data line only while the bus clock is low, except when it forms a start or stop. They also assume that each bus level lasts several system clocks, so the synchroniser never merges a clock edge with a data edge. They further assume the host never attempts a stop while the slave is driving the line low, and that the straps are steady around the end of reset. The bench host drives the bus with half-periods of 16 system clocks. It moves data 4 clocks after each falling bus-clock edge and samples in the middle of the high phase. It issues stops only after an acknowledged write byte or a not-acknowledged read byte.

// File: rtl/cam_ctl_pkg.sv
package cam_ctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_SKIP
    } bus_st_t;

    localparam int CTRL_W  = 5;
    localparam int B_LIN   = 0;
    localparam int B_AEC   = 1;
    localparam int B_AGC   = 2;
    localparam int B_BKL   = 3;
    localparam int B_STD   = 4;
    localparam logic [7:0] IDX_CTRL = 8'd0;
endpackage

// File: rtl/cam_bus_sync.sv
module cam_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_hi,
    output logic sda_hi,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_q;
    logic [STAGES:0] sda_q;
    logic            scl_pv;
    logic            sda_pv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[STAGES-1:0], scl_i};
            sda_q <= {sda_q[STAGES-1:0], sda_i};
        end
    end

    always_comb begin
        scl_hi    = scl_q[STAGES-1];
        sda_hi    = sda_q[STAGES-1];
        scl_pv    = scl_q[STAGES];
        sda_pv    = sda_q[STAGES];
        scl_rise  = scl_hi && !scl_pv;
        scl_fall  = !scl_hi && scl_pv;
        start_det = scl_hi && scl_pv && sda_pv && !sda_hi;
        stop_det  = scl_hi && scl_pv && !sda_pv && sda_hi;
    end
endmodule

// File: rtl/cam_reg_bank.sv
module cam_reg_bank
    import cam_ctl_pkg::*;
#(
    parameter int STAT_BYTES = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CTRL_W-1:0]       strap_ctrl,
    input  logic                    wr_en,
    input  logic [7:0]              idx,
    input  logic [7:0]              wr_data,
    input  logic [STAT_BYTES*8-1:0] stat_i,
    output logic [7:0]              rd_data,
    output logic [CTRL_W-1:0]       ctrl_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= strap_ctrl;
        end else if (wr_en && idx == IDX_CTRL) begin
            ctrl_q <= wr_data[CTRL_W-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        if (idx == IDX_CTRL) begin
            rd_data[CTRL_W-1:0] = ctrl_q;
        end
        for (int k = 0; k < STAT_BYTES; k++) begin
            if (idx == 8'(k + 1)) begin
                rd_data = stat_i[(STAT_BYTES-k)*8-1 -: 8];
            end
        end
    end

    // R7: control byte moves only on a write strobe
    p_ctrl_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/cam_ctl_slave.sv
module cam_ctl_slave
    import cam_ctl_pkg::*;
#(
    parameter int         ADDR_W     = 7,
    parameter logic [4:0] ADDR_HI    = 5'b01011,
    parameter int         STAT_BYTES = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_oe_o,
    input  logic [1:0]              strap_addr_i,
    input  logic                    strap_linear_i,
    input  logic                    strap_aec_i,
    input  logic                    strap_agc_i,
    input  logic                    strap_backlit_i,
    input  logic                    strap_std_i,
    input  logic [STAT_BYTES*8-1:0] stat_i,
    output logic                    linear_o,
    output logic                    aec_o,
    output logic                    agc_o,
    output logic                    backlit_o,
    output logic                    std_o
);
    localparam logic [3:0] BITS_FULL = 4'd8;
    localparam logic [3:0] BIT_LAST  = 4'd7;
    localparam logic [2:0] BYTE_MAX  = 3'd7;

    logic scl_hi, sda_hi, scl_rise, scl_fall, start_det, stop_det;
    bus_st_t state, state_n;
    logic [3:0] bit_cnt;
    logic [2:0] byte_cnt;
    logic [7:0] sh;
    logic [7:0] ptr;
    logic       rw;
    logic       mack_ok;
    logic       byte_done;
    logic       addr_hit;
    logic       reg_we;
    logic [7:0] rd_data;
    logic [CTRL_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] my_addr;

    cam_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_hi(scl_hi), .sda_hi(sda_hi), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
    );

    cam_reg_bank #(.STAT_BYTES(STAT_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .strap_ctrl({strap_std_i, strap_backlit_i, strap_agc_i, strap_aec_i, strap_linear_i}),
        .wr_en(reg_we), .idx(ptr), .wr_data(sh), .stat_i(stat_i),
        .rd_data(rd_data), .ctrl_q(ctrl_q)
    );

    always_comb begin
        my_addr   = {ADDR_HI, strap_addr_i};
        byte_done = (bit_cnt == BITS_FULL);
        addr_hit  = (sh[7:1] == my_addr);
    end

    // next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = ST_RX;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: state_n = ST_IDLE;
                ST_RX:   if (scl_fall && byte_done)
                             state_n = (byte_cnt == 3'd0 && !addr_hit) ? ST_SKIP : ST_ACK;
                ST_ACK:  if (scl_fall)
                             state_n = (rw && byte_cnt >= 3'd2) ? ST_TX : ST_RX;
                ST_TX:   if (scl_fall && bit_cnt == BIT_LAST) state_n = ST_MACK;
                ST_MACK: if (scl_fall) state_n = mack_ok ? ST_TX : ST_SKIP;
                ST_SKIP: state_n = ST_SKIP;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            byte_cnt <= '0;
            sh       <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            mack_ok  <= 1'b0;
        end else begin
            state <= state_n;
            if (start_det || stop_det) begin
                bit_cnt  <= '0;
                byte_cnt <= '0;
            end else begin
                unique case (state)
                    ST_RX: begin
                        if (scl_rise && !byte_done) begin
                            sh      <= {sh[6:0], sda_hi};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && byte_done) begin
                            bit_cnt <= '0;
                            if (byte_cnt != BYTE_MAX) byte_cnt <= byte_cnt + 3'd1;
                            if (byte_cnt == 3'd0)      rw  <= sh[0];
                            else if (byte_cnt == 3'd1) ptr <= sh;
                            else                       ptr <= ptr + 8'd1;
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall && rw && byte_cnt >= 3'd2) begin
                            sh      <= rd_data;
                            ptr     <= ptr + 8'd1;
                            bit_cnt <= '0;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall && bit_cnt != BIT_LAST) begin
                            sh      <= {sh[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= !sda_hi;
                        end else if (scl_fall && mack_ok) begin
                            sh      <= rd_data;
                            ptr     <= ptr + 8'd1;
                            bit_cnt <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe_o  = (state == ST_ACK) || (state == ST_TX && !sh[7]);
        reg_we    = (state == ST_RX) && scl_fall && byte_done && !rw &&
                    (byte_cnt >= 3'd2) && !start_det && !stop_det;
        linear_o  = ctrl_q[B_LIN];
        aec_o     = ctrl_q[B_AEC];
        agc_o     = ctrl_q[B_AGC] && ctrl_q[B_AEC];
        backlit_o = ctrl_q[B_BKL];
        std_o     = ctrl_q[B_STD];
    end

    p_oe_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_hi) && scl_hi) |-> $stable(sda_oe_o));

    p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_RX && bit_cnt == 4'd0 && byte_cnt == 3'd0));

    p_stop_idles_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    p_skip_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP && !start_det && !stop_det) |=> (state == ST_SKIP));
endmodule

// File: tb/cam_ctl_slave_test.sv
module cam_ctl_slave_test;
    localparam int H = 16;
    localparam int Q = 4;
    localparam logic [4:0] AHI = 5'b01011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic hlow = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [1:0] s_addr = 2'b10;
    logic [4:0] s_ctrl = '0;
    logic [23:0] stat = 24'h0;
    logic linear_o, aec_o, agc_o, backlit_o, std_o;
    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = !(hlow || sda_oe);

    cam_ctl_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_addr_i(s_addr), .strap_linear_i(s_ctrl[0]), .strap_aec_i(s_ctrl[1]),
        .strap_agc_i(s_ctrl[2]), .strap_backlit_i(s_ctrl[3]), .strap_std_i(s_ctrl[4]),
        .stat_i(stat), .linear_o(linear_o), .aec_o(aec_o), .agc_o(agc_o),
        .backlit_o(backlit_o), .std_o(std_o)
    );

    function automatic logic [4:0] eff(input logic [4:0] c);
        return {c[4], c[3], c[2] & c[1], c[1], c[0]};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic outs_check(input string req, input logic [4:0] c);
        logic [4:0] o;
        o = {std_o, backlit_o, agc_o, aec_o, linear_o};
        check(o == eff(c), req, o, eff(c));
    endtask

    task automatic bus_start;
        tick(Q); hlow = 1'b0; tick(H); scl = 1'b1; tick(H); hlow = 1'b1; tick(H); scl = 1'b0;
    endtask

    task automatic bus_stop;
        tick(Q); hlow = 1'b1; tick(H); scl = 1'b1; tick(H); hlow = 1'b0; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            tick(Q); hlow = !b[i]; tick(H - Q); scl = 1'b1; tick(H); scl = 1'b0;
        end
        tick(Q); hlow = 1'b0; tick(H - Q); scl = 1'b1;
        tick(H / 2); ack = !sda_line; tick(H - H / 2); scl = 1'b0;
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        tick(Q); hlow = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(H); scl = 1'b1; tick(H / 2); d[i] = sda_line; tick(H - H / 2); scl = 1'b0;
        end
        tick(Q); hlow = !nack; tick(H - Q); scl = 1'b1; tick(H); scl = 1'b0;
        tick(Q); hlow = 1'b0;
    endtask

    task automatic wr_msg(input logic [7:0] idx, input int n, input logic [23:0] d);
        logic a;
        bus_start;
        send_byte({AHI, s_addr, 1'b0}, a); check(a, "R3 addr ack", a, 1);
        send_byte(idx, a);                 check(a, "R3 index ack", a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(d[23-8*i -: 8], a);  check(a, "R3 data ack", a, 1);
        end
        bus_stop;
    endtask

    task automatic rd_hdr(input logic [7:0] idx);
        logic a;
        bus_start;
        send_byte({AHI, s_addr, 1'b1}, a); check(a, "R5 read addr ack", a, 1);
        send_byte(idx, a);                 check(a, "R5 read index ack", a, 1);
    endtask

    task automatic do_reset;
        rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(2);
    endtask

    initial begin
        logic a;
        logic [7:0] d0, d1, d2;
        logic [4:0] cur;
        tick(2);
        // R1: every strap combination
        for (int s = 0; s < 32; s++) begin
            s_ctrl = 5'(s);
            do_reset;
            outs_check("R1 strap defaults", s_ctrl);
        end
        check(sda_line == 1'b1, "R1 line released", sda_line, 1);

        s_ctrl = 5'b10011; s_addr = 2'b10;
        do_reset;
        cur = 5'b10011;
        // R2: all 128 addresses
        for (int ad = 0; ad < 128; ad++) begin
            bus_start;
            send_byte({7'(ad), 1'b0}, a);
            bus_stop;
            check(a == (7'(ad) == {AHI, s_addr}), "R2 address ack", a, (7'(ad) == {AHI, s_addr}));
        end
        bus_start;
        send_byte({AHI, 2'b01, 1'b0}, a); check(!a, "R2 foreign addr", a, 0);
        send_byte(8'h00, a);              check(!a, "R2 foreign index", a, 0);
        send_byte(8'h0C, a);              check(!a, "R2 foreign data", a, 0);
        bus_stop;
        outs_check("R2 foreign write ignored", cur);
        s_addr = 2'b01;
        bus_start; send_byte({AHI, 2'b01, 1'b0}, a); bus_stop;
        check(a, "R2 strap address follows pins", a, 1);
        s_addr = 2'b10;

        // R3/R4/R5: every control value, upper bits set to junk
        for (int v = 0; v < 32; v++) begin
            wr_msg(8'h00, 1, {3'(v), 5'(v), 16'h0});
            outs_check("R3 control write", 5'(v));
            check(agc_o == (v[2] & v[1]), "R4 agc qualified", agc_o, v[2] & v[1]);
            rd_hdr(8'h00); recv_byte(1'b1, d0); bus_stop;
            check(d0 == {3'b000, 5'(v)}, "R5 control readback", d0, v);
        end

        // R6: status reads
        stat = 24'hA5C37E;
        rd_hdr(8'h01);
        recv_byte(1'b0, d0); recv_byte(1'b0, d1); recv_byte(1'b1, d2); bus_stop;
        check(d0 == 8'hA5, "R6 status byte 1", d0, 8'hA5);
        check(d1 == 8'hC3, "R6 status byte 2", d1, 8'hC3);
        check(d2 == 8'h7E, "R6 status byte 3", d2, 8'h7E);
        rd_hdr(8'h00);
        recv_byte(1'b0, d0); recv_byte(1'b0, d1); recv_byte(1'b1, d2); bus_stop;
        check(d0 == 8'h1F, "R6 run from index 0", d0, 8'h1F);
        check(d1 == 8'hA5 && d2 == 8'hC3, "R6 run continues", {d1, d2}, 16'hA5C3);
        rd_hdr(8'h04); recv_byte(1'b1, d0);
        // R8: line released after host not-acknowledge
        tick(H - Q); check(sda_line == 1'b1, "R8 released after nack", sda_line, 1);
        scl = 1'b1; tick(H / 2); check(sda_line == 1'b1, "R8 released on next clock", sda_line, 1);
        scl = 1'b0; tick(H);
        bus_stop;
        check(d0 == 8'h00, "R6 unused index", d0, 0);

        // R7: five-byte writes
        wr_msg(8'h00, 3, 24'h0AFFFF);
        outs_check("R7 five-byte write at 0", 5'h0A);
        rd_hdr(8'h01); recv_byte(1'b1, d0); bus_stop;
        check(d0 == 8'hA5, "R7 status untouched", d0, 8'hA5);
        wr_msg(8'h02, 3, 24'h1F1F1F);
        outs_check("R7 read-only indices ignored", 5'h0A);

        // R9: repeated start mid-message, then stop resumes idle
        bus_start;
        send_byte({AHI, s_addr, 1'b0}, a);
        send_byte(8'h00, a);
        bus_start;
        send_byte({AHI, s_addr, 1'b0}, a); check(a, "R9 restart address ack", a, 1);
        send_byte(8'h00, a);
        send_byte(8'h15, a);
        bus_stop;
        outs_check("R9 write after restart", 5'h15);
        bus_start; send_byte({AHI, s_addr, 1'b0}, a); bus_stop;
        bus_start; send_byte({AHI, s_addr, 1'b0}, a); bus_stop;
        check(a, "R9 stop then new frame", a, 1);
        // R10: drive changed only while clock low (also guarded in RTL)
        check(sda_line == 1'b1, "R10 idle line high", sda_line, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule